// File: doc/BRIEF.md
# Completion-Timed Memory Access Pulse Sequencer

This block runs one access of a single-ended, bit-interleaved memory array per request. It samples an active-low enable and an active-low write select on the clock edge. It then raises either a read pulse or a write pulse. The pulse has no fixed width. It ends when a completion strobe arrives. A write ends on the write-done strobe. A read ends on a done strobe from a worst-case replica column, followed by a programmable margin of extra cycles. While neither pulse is high, the block asks for precharge so that every bit-line rests high.

During a write, the block drives the bit-lines of the selected interleave columns with the stored data bit and leaves the other bit-lines high. During a read, it releases all bit-lines and captures the already-sensed value into an output register as the read pulse ends. A cycle timeout ends any pulse whose strobe never arrives and sets a sticky error flag.

Top module: `accPulseSeq`

## Requirements
- R1: After reset, readPulse, writePulse, busy, timeoutErr, every blDrive bit and dataOut are 0, and prechargeEn is 1.
- R2: On an edge with chipEnN=0, writeEnN=0 and busy=0, writePulse rises. It stays high until the edge that samples writeDone=1, and falls at that edge.
- R3: On an edge with chipEnN=0, writeEnN=1 and busy=0, readPulse rises. On the edge that samples readDone=1, the value of marginCycles (0 to 15) is taken. readPulse then stays high for exactly that many more cycles, so the pulse lasts (cycles before the strobe edge) + marginCycles cycles.
- R4: While chipEnN=1, no pulse starts, and strobes on readDone or writeDone while idle have no effect.
- R5: prechargeEn is 1 exactly when readPulse and writePulse are both 0.
- R6: dataIn and colSel are captured on the request edge. While writePulse is high, bit-line index b*COLS+c (b = data bit, c = interleave column) has blDrive=1 and blValue=captured data bit b when colSel[c]=1. Otherwise it has blDrive=0 and blValue=1.
- R7: While readPulse is high, no blDrive bit is set and precharge is off. On the edge where a strobe-ended read pulse falls, dataOut loads senseIn.
- R8: dataOut changes at no other time. It holds through writes, idle cycles and timed-out reads.
- R9: busy is high from the pulse start edge until one edge after the pulse ends. Requests seen while busy is high are ignored.
- R10: If no strobe arrives, the pulse ends after timeoutLimit cycles (0 is treated as 1) and timeoutErr is set. timeoutErr stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipEnN | input | 1 | Access request, active low |
| writeEnN | input | 1 | 0 = write, 1 = read |
| dataIn | input | DATA_W | Write data |
| colSel | input | COLS | Interleave column select, one bit per column |
| senseIn | input | DATA_W | Sensed value of the selected bit-lines |
| readDone | input | 1 | Delayed replica completion strobe |
| writeDone | input | 1 | Write completion strobe |
| marginCycles | input | 4 | Extra read pulse cycles after readDone |
| timeoutLimit | input | TO_W | Maximum cycles to wait for a strobe |
| readPulse | output | 1 | Read pulse |
| writePulse | output | 1 | Write pulse |
| prechargeEn | output | 1 | Bit-line precharge request |
| blDrive | output | DATA_W*COLS | Per bit-line write driver enable |
| blValue | output | DATA_W*COLS | Per bit-line driven level |
| dataOut | output | DATA_W | Latched read data |
| busy | output | 1 | Access in progress |
| timeoutErr | output | 1 | Sticky strobe timeout flag |

## Verification
The hardest situation to reach from the ports is a request that arrives mid-pulse. It must be lost for good, even though chipEnN is low again after recovery. The stimulus holds a read request low for one cycle inside a long write. It then checks that no read pulse follows and that dataOut is unchanged. The timeout path is also hard to reach, because no real replica ever stays silent. The bench reaches it by withholding the strobe and by programming a limit of 0. It then checks that a later good access does not clear the flag.

// File: rtl/accPulsePkg.sv
package accPulsePkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_MARGIN,
    ST_RECOVER
  } seqState_t;

  typedef struct packed {
    logic loadReq;
    logic wrActive;
    logic rdActive;
    logic capture;
  } pulseCtl_t;
endpackage

// File: rtl/accPulseCtrl.sv
module accPulseCtrl
  import accPulsePkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            chipEnN,
  input  logic            writeEnN,
  input  logic            readDone,
  input  logic            writeDone,
  input  logic [3:0]      marginCycles,
  input  logic [TO_W-1:0] timeoutLimit,
  output pulseCtl_t       ctl,
  output logic            busy,
  output logic            timeoutErr
);
  seqState_t       state;
  logic [TO_W-1:0] waitCnt;
  logic [3:0]      marginCnt;
  logic            limitHit;

  assign limitHit = ({1'b0, waitCnt} + 1'b1) >= {1'b0, timeoutLimit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      waitCnt    <= '0;
      marginCnt  <= '0;
      timeoutErr <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (!chipEnN) begin
          waitCnt <= '0;
          state   <= writeEnN ? ST_READ : ST_WRITE;
        end
        ST_WRITE: begin
          if (writeDone) state <= ST_RECOVER;
          else if (limitHit) begin
            state      <= ST_RECOVER;
            timeoutErr <= 1'b1;
          end else waitCnt <= waitCnt + 1'b1;
        end
        ST_READ: begin
          if (readDone) begin
            if (marginCycles == 4'd0) state <= ST_RECOVER;
            else begin
              state     <= ST_MARGIN;
              marginCnt <= marginCycles;
            end
          end else if (limitHit) begin
            state      <= ST_RECOVER;
            timeoutErr <= 1'b1;
          end else waitCnt <= waitCnt + 1'b1;
        end
        ST_MARGIN: begin
          if (marginCnt == 4'd1) state <= ST_RECOVER;
          else marginCnt <= marginCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadReq  = (state == ST_IDLE) && !chipEnN;
    ctl.wrActive = (state == ST_WRITE);
    ctl.rdActive = (state == ST_READ) || (state == ST_MARGIN);
    ctl.capture  = ((state == ST_READ) && readDone && (marginCycles == 4'd0)) ||
                   ((state == ST_MARGIN) && (marginCnt == 4'd1));
  end

  assign busy = (state != ST_IDLE);

  a_r2_write_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.wrActive) |-> $past(!chipEnN && !writeEnN));
  a_r3_read_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && $past(state) != ST_READ) |-> $past(!chipEnN && writeEnN));
  a_r2_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrActive && !writeDone && !limitHit) |=> ctl.wrActive);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(timeoutErr) |-> timeoutErr);
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.wrActive || ctl.rdActive) |-> busy && !(ctl.wrActive || ctl.rdActive));
endmodule

// File: rtl/accPulseDatapath.sv
module accPulseDatapath
  import accPulsePkg::*;
#(
  parameter int DATA_W = 4,
  parameter int COLS   = 4,
  localparam int NBL   = DATA_W * COLS
) (
  input  logic              clk,
  input  logic              rstN,
  input  pulseCtl_t         ctl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [COLS-1:0]   colSel,
  input  logic [DATA_W-1:0] senseIn,
  output logic              readPulse,
  output logic              writePulse,
  output logic              prechargeEn,
  output logic [NBL-1:0]    blDrive,
  output logic [NBL-1:0]    blValue,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] dataLat;
  logic [COLS-1:0]   selLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLat <= '0;
      selLat  <= '0;
      dataOut <= '0;
    end else begin
      if (ctl.loadReq) begin
        dataLat <= dataIn;
        selLat  <= colSel;
      end
      if (ctl.capture) dataOut <= senseIn;
    end
  end

  assign readPulse   = ctl.rdActive;
  assign writePulse  = ctl.wrActive;
  assign prechargeEn = !(ctl.rdActive || ctl.wrActive);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign blDrive[b*COLS+c] = ctl.wrActive && selLat[c];
      assign blValue[b*COLS+c] = (ctl.wrActive && selLat[c]) ? dataLat[b] : 1'b1;
    end
  end

  a_r5_no_fight: assert property (@(posedge clk) disable iff (!rstN)
    (|blDrive) |-> !prechargeEn);
  a_r7_read_float: assert property (@(posedge clk) disable iff (!rstN)
    readPulse |-> (blDrive == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $past(ctl.capture));
endmodule

// File: rtl/accPulseSeq.sv
module accPulseSeq
  import accPulsePkg::*;
#(
  parameter int DATA_W = 4,
  parameter int COLS   = 4,
  parameter int TO_W   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   chipEnN,
  input  logic                   writeEnN,
  input  logic [DATA_W-1:0]      dataIn,
  input  logic [COLS-1:0]        colSel,
  input  logic [DATA_W-1:0]      senseIn,
  input  logic                   readDone,
  input  logic                   writeDone,
  input  logic [3:0]             marginCycles,
  input  logic [TO_W-1:0]        timeoutLimit,
  output logic                   readPulse,
  output logic                   writePulse,
  output logic                   prechargeEn,
  output logic [DATA_W*COLS-1:0] blDrive,
  output logic [DATA_W*COLS-1:0] blValue,
  output logic [DATA_W-1:0]      dataOut,
  output logic                   busy,
  output logic                   timeoutErr
);
  pulseCtl_t ctl;

  accPulseCtrl #(.TO_W(TO_W)) u_ctrl (
    .clk, .rstN, .chipEnN, .writeEnN, .readDone, .writeDone,
    .marginCycles, .timeoutLimit, .ctl, .busy, .timeoutErr
  );

  accPulseDatapath #(.DATA_W(DATA_W), .COLS(COLS)) u_dp (
    .clk, .rstN, .ctl, .dataIn, .colSel, .senseIn,
    .readPulse, .writePulse, .prechargeEn, .blDrive, .blValue, .dataOut
  );
endmodule

// File: tb/accPulseSeq_tb.sv
module accPulseSeq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int NC = 4;

  logic clk = 0, rstN = 0;
  logic chipEnN = 1, writeEnN = 1, readDone = 0, writeDone = 0;
  logic [DW-1:0] dataIn = '0, senseIn = '0;
  logic [NC-1:0] colSel = '0;
  logic [3:0] marginCycles = '0;
  logic [7:0] timeoutLimit = 8'd20;
  logic readPulse, writePulse, prechargeEn, busy, timeoutErr;
  logic [DW*NC-1:0] blDrive, blValue;
  logic [DW-1:0] dataOut;

  int checks = 0, errors = 0;
  logic [DW-1:0] expOut = '0;

  // {wr, data, sel, dly, margin, sense}
  localparam logic [20:0] VECS [0:7] = '{
    {1'b1, 4'hA, 4'b0001, 4'd0, 4'd0, 4'h0},
    {1'b0, 4'h0, 4'b0000, 4'd2, 4'd0, 4'h5},
    {1'b1, 4'h3, 4'b0110, 4'd4, 4'd0, 4'h0},
    {1'b0, 4'h0, 4'b0000, 4'd0, 4'd3, 4'hC},
    {1'b1, 4'hF, 4'b1111, 4'd1, 4'd0, 4'h0},
    {1'b0, 4'h0, 4'b0000, 4'd1, 4'd15, 4'h9},
    {1'b1, 4'h0, 4'b1000, 4'd6, 4'd0, 4'h0},
    {1'b0, 4'h0, 4'b0000, 4'd5, 4'd1, 4'h6}
  };

  accPulseSeq u_dut (
    .clk, .rstN, .chipEnN, .writeEnN, .dataIn, .colSel, .senseIn,
    .readDone, .writeDone, .marginCycles, .timeoutLimit,
    .readPulse, .writePulse, .prechargeEn, .blDrive, .blValue,
    .dataOut, .busy, .timeoutErr
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doAccess(input bit wr, input logic [3:0] d, input logic [3:0] s,
                          input int dly, input logic [3:0] m, input logic [3:0] sv);
    int hi;
    logic [15:0] expDrv, expVal;
    chipEnN = 0; writeEnN = !wr; dataIn = d; colSel = s;
    marginCycles = m; senseIn = sv;
    @(negedge clk);
    chipEnN = 1; dataIn = ~d; colSel = ~s;
    for (int b = 0; b < DW; b++)
      for (int c = 0; c < NC; c++) begin
        expDrv[b*NC+c] = wr && s[c];
        expVal[b*NC+c] = (wr && s[c]) ? d[b] : 1'b1;
      end
    check(busy == 1, "R9 busy at start", busy, 1);
    check(prechargeEn == 0, "R5 precharge off in pulse", prechargeEn, 0);
    if (wr) begin
      check(blDrive == expDrv, "R6 drive", blDrive, expDrv);
      check(blValue == expVal, "R6 value", blValue, expVal);
    end else
      check(blDrive == 0, "R7 float", blDrive, 0);
    hi = 0;
    for (int k = 0; k < dly; k++) begin
      if (wr ? writePulse : readPulse) hi++;
      @(negedge clk);
    end
    if (wr) writeDone = 1; else readDone = 1;
    if (wr ? writePulse : readPulse) hi++;
    @(negedge clk);
    writeDone = 0; readDone = 0;
    while ((wr ? writePulse : readPulse) && hi < 60) begin
      hi++;
      @(negedge clk);
    end
    if (wr) check(hi == dly + 1, "R2 write pulse length", hi, dly + 1);
    else check(hi == dly + 1 + m, "R3 read pulse length", hi, dly + 1 + m);
    if (!wr) expOut = sv;
    check(dataOut == expOut, wr ? "R8 hold over write" : "R7 capture", dataOut, expOut);
    check(busy == 1 && prechargeEn == 1, "R9/R5 recovery cycle", {busy, prechargeEn}, 3);
    @(negedge clk);
    check(busy == 0, "R9 busy clears", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(readPulse == 0 && writePulse == 0 && busy == 0 && timeoutErr == 0,
          "R1 reset controls", {readPulse, writePulse, busy, timeoutErr}, 0);
    check(prechargeEn == 1 && blDrive == 0 && dataOut == 0, "R1 reset datapath",
          {prechargeEn, dataOut}, 16);
    rstN = 1;
    @(negedge clk);

    foreach (VECS[i])
      doAccess(VECS[i][20], VECS[i][19:16], VECS[i][15:12],
               int'(VECS[i][11:8]), VECS[i][7:4], VECS[i][3:0]);

    // R4 idle with stray strobes
    readDone = 1; writeDone = 1; senseIn = 4'h3;
    repeat (3) begin
      @(negedge clk);
      check(!readPulse && !writePulse && !busy && prechargeEn, "R4 idle",
            {readPulse, writePulse, busy}, 0);
    end
    readDone = 0; writeDone = 0;
    check(dataOut == expOut, "R4 strobe in idle no capture", dataOut, expOut);

    // R9 request during write is ignored
    chipEnN = 0; writeEnN = 0; dataIn = 4'h1; colSel = 4'b0001;
    @(negedge clk);
    chipEnN = 1;
    @(negedge clk);
    chipEnN = 0; writeEnN = 1; senseIn = 4'hE;
    @(negedge clk);
    chipEnN = 1;
    check(writePulse && !readPulse, "R9 ignored mid-pulse", {writePulse, readPulse}, 2);
    writeDone = 1;
    @(negedge clk);
    writeDone = 0;
    repeat (3) begin
      @(negedge clk);
      check(!readPulse && !writePulse, "R9 no late start", {readPulse, writePulse}, 0);
    end
    check(dataOut == expOut, "R9/R8 dataOut kept", dataOut, expOut);

    // R10 read timeout, limit 5
    timeoutLimit = 8'd5; senseIn = 4'h7;
    chipEnN = 0; writeEnN = 1;
    @(negedge clk);
    chipEnN = 1;
    hi = 0;
    while (readPulse && hi < 60) begin hi++; @(negedge clk); end
    check(hi == 5, "R10 timeout length", hi, 5);
    check(timeoutErr == 1, "R10 error set", timeoutErr, 1);
    check(dataOut == expOut, "R8 no capture on timeout", dataOut, expOut);
    @(negedge clk);

    // R10 limit 0 behaves as 1
    timeoutLimit = 8'd0;
    chipEnN = 0; writeEnN = 0;
    @(negedge clk);
    chipEnN = 1;
    check(writePulse == 1, "R10 limit0 pulse", writePulse, 1);
    @(negedge clk);
    check(writePulse == 0, "R10 limit0 ends after one", writePulse, 0);
    @(negedge clk);

    // R10 sticky after good access
    timeoutLimit = 8'd20;
    doAccess(1'b0, 4'h0, 4'h0, 1, 4'd2, 4'hB);
    check(timeoutErr == 1, "R10 sticky", timeoutErr, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule